// File: doc/BRIEF.md
# Nibble-Wide Call/Return Stack Sequencer

This block runs the stack-frame sequences of a small processor whose data memory is four bits wide and whose program counter is 14 bits. The core hands it one operation at a time. The operation is one of: subroutine call, fast call, return, return-and-skip, interrupt return, register-pair push or pop, and bank-select push or pop. Each operation comes with the target address, the register pair and a snapshot of the current stack pointer, program counter, bank-enable bit, bank-select nibble and status byte. The sequencer moves one nibble per cycle through a synchronous single-port memory. At the end it presents the whole new register state at once, together with a done pulse.

A call frame takes four nibbles, and its slots are not filled in address order. The slot at SP-3 holds the bank-enable bit and the two upper program-counter bits packed into one nibble. The three return flavours each restore a different subset of that frame. Operations enter through a valid/ready handshake. `op_ready` is high only while the block is idle. A request offered while `op_ready` is low is not held or queued. It is dropped and reported on `err`, so the core must wait for `op_ready` before it presents an operation. Memory reads return data one cycle after the read strobe.

Top module: `nib_stack_seq`

## Requirements
- R1: Call (code 0) writes PC[11:8] to SP-4, PC[7:4] to SP-1, PC[3:0] to SP-2 and {bank-enable, 0, PC[13], PC[12]} (bit 3 down to bit 0) to SP-3. It then commits PC = target and SP = SP-4.
- R2: Fast call (code 1) writes the same four-nibble frame as R1. It commits PC = {000, target[10:0]} and SP = SP-4.
- R3: Return (code 2) sets bank-enable, PC[13] and PC[12] from bits 3, 1 and 0 of the nibble at SP+1; bit 2 of that nibble is ignored. It takes PC[11:8] from SP, PC[7:4] from SP+3 and PC[3:0] from SP+2, and commits SP = SP+4.
- R4: Return-and-skip (code 3) behaves as R3. It also drives `skip_next` high for exactly the one cycle in which `done` is high. No other operation raises `skip_next`.
- R5: Interrupt return (code 4) restores PC exactly as in R3 but leaves bank-enable at its input value. It loads the status byte with high nibble from SP+4 and low nibble from SP+5, and commits SP = SP+6.
- R6: Pair push (code 5) writes rp[7:4] to SP-1 and rp[3:0] to SP-2, then SP = SP-2. Pair pop (code 6) loads rp[7:4] from SP+1 and rp[3:0] from SP, then SP = SP+2.
- R7: Bank push (code 7) writes the bank-select nibble to SP-1 and a zero nibble to SP-2, then SP = SP-2. Bank pop (code 8) loads bank-select from SP+1, then SP = SP+2.
- R8: All stack addresses and the committed SP wrap modulo 256.
- R9: Accesses run one per cycle, starting in the cycle after acceptance. `done` is a one-cycle pulse. For writing operations it comes in the cycle after the last write. For reading operations it comes two cycles after the last read strobe. So `done` arrives 5 cycles after acceptance for codes 0 and 1, 6 for codes 2 and 3, 8 for code 4, 3 for codes 5, 7 and 8, and 4 for code 6. `busy` is high from the first access until `done`, and `op_ready` is its inverse.
- R10: All six state outputs change only at the edge that raises `done`. A field that an operation does not produce is committed from the value sampled at acceptance.
- R11: A request offered while busy, or carrying an undefined code (9 to 15), is dropped. `err` is high in the following cycle, and no memory access or state change results from the request.
- R12: Strobes: `mem_we` and `mem_re` are never high together, and both are low while idle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| op_valid | input | 1 | Operation offered |
| op_ready | output | 1 | Block idle, operation will be taken |
| op_code | input | 4 | Operation code (R1 to R7) |
| tgt_addr | input | 14 | Call or fast-call target |
| rp_in | input | 8 | Register pair to push |
| sp_in | input | 8 | Current stack pointer |
| pc_in | input | 14 | Current (return) program counter |
| mbe_in | input | 1 | Current bank-enable bit |
| bank_in | input | 4 | Current bank-select nibble |
| psw_in | input | 8 | Current status byte |
| mem_we | output | 1 | Memory write strobe |
| mem_re | output | 1 | Memory read strobe |
| mem_addr | output | 8 | Memory nibble address |
| mem_wdata | output | 4 | Write nibble |
| mem_rdata | input | 4 | Read nibble, valid one cycle after `mem_re` |
| busy | output | 1 | Sequence in progress |
| done | output | 1 | One-cycle end-of-sequence pulse |
| skip_next | output | 1 | Skip the next instruction |
| err | output | 1 | Previous-cycle request dropped |
| sp_out | output | 8 | Committed stack pointer |
| pc_out | output | 14 | Committed program counter |
| mbe_out | output | 1 | Committed bank-enable bit |
| bank_out | output | 4 | Committed bank-select nibble |
| psw_out | output | 8 | Committed status byte |
| rp_out | output | 8 | Committed register pair |

## Verification
The `done` pulse that ends one sequence and the acceptance of the next operation can fall in the same cycle, because `op_ready` is already high while `done` is high. The bench provokes this by offering a pair pop in the exact cycle a pair push reports `done`, with the SP that push has just committed. It judges the result by the pop returning the pushed pair with SP restored and the expected latency. A second collision is a request arriving during the access cycles of a call. That case is judged by `err` and by the call's frame and committed state being unchanged by the dropped request.

// File: rtl/nss_pkg.sv
package nss_pkg;

  localparam int STEP_W = 3;

  typedef enum logic [3:0] {
    OP_CALL   = 4'd0,
    OP_FCALL  = 4'd1,
    OP_RET    = 4'd2,
    OP_RETSK  = 4'd3,
    OP_RETI   = 4'd4,
    OP_PUSHRP = 4'd5,
    OP_POPRP  = 4'd6,
    OP_PUSHBS = 4'd7,
    OP_POPBS  = 4'd8
  } op_e;

  function automatic logic op_legal(input logic [3:0] code);
    return code <= 4'd8;
  endfunction

  // number of memory access cycles of a sequence
  function automatic logic [STEP_W-1:0] seq_len(input op_e op);
    case (op)
      OP_CALL, OP_FCALL, OP_RET, OP_RETSK: return 3'd4;
      OP_RETI:                             return 3'd6;
      OP_PUSHRP, OP_POPRP, OP_PUSHBS:      return 3'd2;
      default:                             return 3'd1;
    endcase
  endfunction

  function automatic logic seq_reads(input op_e op);
    case (op)
      OP_RET, OP_RETSK, OP_RETI, OP_POPRP, OP_POPBS: return 1'b1;
      default:                                       return 1'b0;
    endcase
  endfunction

  // stack slot offset (relative to SP at acceptance) for access k
  function automatic logic signed [3:0] slot_off(input op_e op, input logic [STEP_W-1:0] k);
    case (op)
      OP_CALL, OP_FCALL:
        case (k)
          3'd0:    return -4'sd4;
          3'd1:    return -4'sd1;
          3'd2:    return -4'sd2;
          default: return -4'sd3;
        endcase
      OP_RET, OP_RETSK, OP_RETI:
        case (k)
          3'd0:    return 4'sd1;
          3'd1:    return 4'sd0;
          3'd2:    return 4'sd3;
          3'd3:    return 4'sd2;
          3'd4:    return 4'sd4;
          default: return 4'sd5;
        endcase
      OP_PUSHRP, OP_PUSHBS:
        return (k == 3'd0) ? -4'sd1 : -4'sd2;
      OP_POPRP:
        return (k == 3'd0) ? 4'sd1 : 4'sd0;
      default:
        return 4'sd1;
    endcase
  endfunction

  // stack pointer adjustment committed at the end of a sequence
  function automatic logic signed [3:0] sp_delta(input op_e op);
    case (op)
      OP_CALL, OP_FCALL:               return -4'sd4;
      OP_RET, OP_RETSK:                return 4'sd4;
      OP_RETI:                         return 4'sd6;
      OP_PUSHRP, OP_PUSHBS:            return -4'sd2;
      default:                         return 4'sd2;
    endcase
  endfunction

endpackage

// File: rtl/nss_ctrl.sv
module nss_ctrl
  import nss_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              start,
  input  op_e               op,
  output logic              busy,
  output logic              acc,
  output logic              rd_mode,
  output logic [STEP_W-1:0] step,
  output logic              cap_vld,
  output logic [STEP_W-1:0] cap_idx,
  output logic              commit
);

  typedef enum logic [1:0] {S_IDLE, S_ACC, S_CAP} st_e;

  st_e  st;
  logic last;

  assign rd_mode = seq_reads(op);
  assign last    = (step == seq_len(op) - STEP_W'(1));
  assign acc     = (st == S_ACC);
  assign busy    = (st != S_IDLE);
  assign commit  = (acc && last && !rd_mode) || (st == S_CAP);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      st      <= S_IDLE;
      step    <= '0;
      cap_vld <= 1'b0;
      cap_idx <= '0;
    end else begin
      cap_vld <= acc && rd_mode;
      cap_idx <= step;
      case (st)
        S_IDLE: begin
          if (start) begin
            st   <= S_ACC;
            step <= '0;
          end
        end
        S_ACC: begin
          if (last) begin
            st <= rd_mode ? S_CAP : S_IDLE;
          end else begin
            step <= step + STEP_W'(1);
          end
        end
        default: st <= S_IDLE;
      endcase
    end
  end

endmodule

// File: rtl/nss_port.sv
module nss_port
  import nss_pkg::*;
#(
  parameter int SP_W = 8,
  parameter int PC_W = 14
)(
  input  op_e               op,
  input  logic              acc,
  input  logic              rd_mode,
  input  logic [STEP_W-1:0] step,
  input  logic [SP_W-1:0]   sp,
  input  logic [PC_W-1:0]   pc,
  input  logic              mbe,
  input  logic [3:0]        bank,
  input  logic [7:0]        rp,
  output logic              mem_we,
  output logic              mem_re,
  output logic [SP_W-1:0]   mem_addr,
  output logic [3:0]        mem_wdata
);

  logic signed [3:0] off;

  assign off      = slot_off(op, step);
  assign mem_addr = sp + {{(SP_W-4){off[3]}}, off};
  assign mem_we   = acc && !rd_mode;
  assign mem_re   = acc && rd_mode;

  always_comb begin
    mem_wdata = 4'h0;
    case (op)
      OP_CALL, OP_FCALL:
        case (step)
          3'd0:    mem_wdata = pc[11:8];
          3'd1:    mem_wdata = pc[7:4];
          3'd2:    mem_wdata = pc[3:0];
          default: mem_wdata = {mbe, 1'b0, pc[PC_W-1], pc[PC_W-2]};
        endcase
      OP_PUSHRP: mem_wdata = (step == 3'd0) ? rp[7:4] : rp[3:0];
      OP_PUSHBS: mem_wdata = (step == 3'd0) ? bank : 4'h0;
      default:   mem_wdata = 4'h0;
    endcase
  end

endmodule

// File: rtl/nss_restore.sv
module nss_restore
  import nss_pkg::*;
#(
  parameter int PC_W = 14
)(
  input  op_e               op,
  input  logic              cap_vld,
  input  logic [STEP_W-1:0] idx,
  input  logic [3:0]        d,
  input  logic [PC_W-1:0]   pc_q,
  input  logic              mbe_q,
  input  logic [3:0]        bank_q,
  input  logic [7:0]        psw_q,
  input  logic [7:0]        rp_q,
  output logic [PC_W-1:0]   pc_n,
  output logic              mbe_n,
  output logic [3:0]        bank_n,
  output logic [7:0]        psw_n,
  output logic [7:0]        rp_n
);

  logic unused_rsvd;
  assign unused_rsvd = d[2];

  always_comb begin
    pc_n   = pc_q;
    mbe_n  = mbe_q;
    bank_n = bank_q;
    psw_n  = psw_q;
    rp_n   = rp_q;
    if (cap_vld) begin
      case (op)
        OP_RET, OP_RETSK, OP_RETI:
          case (idx)
            3'd0: begin
              pc_n[PC_W-1] = d[1];
              pc_n[PC_W-2] = d[0];
              if (op != OP_RETI) mbe_n = d[3];
            end
            3'd1:    pc_n[11:8] = d;
            3'd2:    pc_n[7:4]  = d;
            3'd3:    pc_n[3:0]  = d;
            3'd4:    psw_n[7:4] = d;
            default: psw_n[3:0] = d;
          endcase
        OP_POPRP: begin
          if (idx == 3'd0) rp_n[7:4] = d;
          else             rp_n[3:0] = d;
        end
        OP_POPBS: bank_n = d;
        default: ;
      endcase
    end
  end

endmodule

// File: rtl/nib_stack_seq.sv
module nib_stack_seq
  import nss_pkg::*;
#(
  parameter int SP_W = 8,
  parameter int PC_W = 14
)(
  input  logic            clk,
  input  logic            rst_n,
  input  logic            op_valid,
  output logic            op_ready,
  input  logic [3:0]      op_code,
  input  logic [PC_W-1:0] tgt_addr,
  input  logic [7:0]      rp_in,
  input  logic [SP_W-1:0] sp_in,
  input  logic [PC_W-1:0] pc_in,
  input  logic            mbe_in,
  input  logic [3:0]      bank_in,
  input  logic [7:0]      psw_in,
  output logic            mem_we,
  output logic            mem_re,
  output logic [SP_W-1:0] mem_addr,
  output logic [3:0]      mem_wdata,
  input  logic [3:0]      mem_rdata,
  output logic            busy,
  output logic            done,
  output logic            skip_next,
  output logic            err,
  output logic [SP_W-1:0] sp_out,
  output logic [PC_W-1:0] pc_out,
  output logic            mbe_out,
  output logic [3:0]      bank_out,
  output logic [7:0]      psw_out,
  output logic [7:0]      rp_out
);

  localparam int FAST_W = PC_W - 3;

  // working copy of the state, loaded at acceptance
  op_e             w_op;
  logic [SP_W-1:0] w_sp;
  logic [PC_W-1:0] w_pc;
  logic [PC_W-1:0] w_tgt;
  logic            w_mbe;
  logic [3:0]      w_bank;
  logic [7:0]      w_psw;
  logic [7:0]      w_rp;

  logic [PC_W-1:0] n_pc;
  logic            n_mbe;
  logic [3:0]      n_bank;
  logic [7:0]      n_psw;
  logic [7:0]      n_rp;

  logic              accept;
  logic              acc;
  logic              rd_mode;
  logic [STEP_W-1:0] step;
  logic              cap_vld;
  logic [STEP_W-1:0] cap_idx;
  logic              commit;
  logic signed [3:0] dsp;

  assign op_ready = !busy;
  assign accept   = op_valid && op_ready && op_legal(op_code);
  assign dsp      = sp_delta(w_op);

  nss_ctrl u_ctrl (
    .clk     (clk),
    .rst_n   (rst_n),
    .start   (accept),
    .op      (w_op),
    .busy    (busy),
    .acc     (acc),
    .rd_mode (rd_mode),
    .step    (step),
    .cap_vld (cap_vld),
    .cap_idx (cap_idx),
    .commit  (commit)
  );

  nss_port #(.SP_W(SP_W), .PC_W(PC_W)) u_port (
    .op        (w_op),
    .acc       (acc),
    .rd_mode   (rd_mode),
    .step      (step),
    .sp        (w_sp),
    .pc        (w_pc),
    .mbe       (w_mbe),
    .bank      (w_bank),
    .rp        (w_rp),
    .mem_we    (mem_we),
    .mem_re    (mem_re),
    .mem_addr  (mem_addr),
    .mem_wdata (mem_wdata)
  );

  nss_restore #(.PC_W(PC_W)) u_rest (
    .op      (w_op),
    .cap_vld (cap_vld),
    .idx     (cap_idx),
    .d       (mem_rdata),
    .pc_q    (w_pc),
    .mbe_q   (w_mbe),
    .bank_q  (w_bank),
    .psw_q   (w_psw),
    .rp_q    (w_rp),
    .pc_n    (n_pc),
    .mbe_n   (n_mbe),
    .bank_n  (n_bank),
    .psw_n   (n_psw),
    .rp_n    (n_rp)
  );

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      w_op   <= OP_CALL;
      w_sp   <= '0;
      w_pc   <= '0;
      w_tgt  <= '0;
      w_mbe  <= 1'b0;
      w_bank <= 4'h0;
      w_psw  <= 8'h00;
      w_rp   <= 8'h00;
    end else if (accept) begin
      w_op   <= op_e'(op_code);
      w_sp   <= sp_in;
      w_pc   <= pc_in;
      w_tgt  <= tgt_addr;
      w_mbe  <= mbe_in;
      w_bank <= bank_in;
      w_psw  <= psw_in;
      w_rp   <= rp_in;
    end else if (cap_vld) begin
      w_pc   <= n_pc;
      w_mbe  <= n_mbe;
      w_bank <= n_bank;
      w_psw  <= n_psw;
      w_rp   <= n_rp;
    end
  end

  // all state leaves together at the end of a sequence
  always_ff @(posedge clk) begin
    if (!rst_n) begin
      sp_out    <= '0;
      pc_out    <= '0;
      mbe_out   <= 1'b0;
      bank_out  <= 4'h0;
      psw_out   <= 8'h00;
      rp_out    <= 8'h00;
      done      <= 1'b0;
      skip_next <= 1'b0;
      err       <= 1'b0;
    end else begin
      done      <= commit;
      skip_next <= commit && (w_op == OP_RETSK);
      err       <= op_valid && !accept;
      if (commit) begin
        sp_out <= w_sp + {{(SP_W-4){dsp[3]}}, dsp};
        case (w_op)
          OP_CALL:  pc_out <= w_tgt;
          OP_FCALL: pc_out <= {{(PC_W-FAST_W){1'b0}}, w_tgt[FAST_W-1:0]};
          default:  pc_out <= n_pc;
        endcase
        mbe_out  <= n_mbe;
        bank_out <= n_bank;
        psw_out  <= n_psw;
        rp_out   <= n_rp;
      end
    end
  end

endmodule

// File: rtl/nss_chk.sv
module nss_chk #(
  parameter int SP_W = 8,
  parameter int PC_W = 14
)(
  input logic            clk,
  input logic            rst_n,
  input logic            op_valid,
  input logic            busy,
  input logic            done,
  input logic            skip_next,
  input logic            err,
  input logic            mem_we,
  input logic            mem_re,
  input logic [SP_W-1:0] sp_out,
  input logic [PC_W-1:0] pc_out
);

  p_one_strobe_r12: assert property (@(posedge clk) disable iff (!rst_n)
    !(mem_we && mem_re));

  p_idle_quiet_r12: assert property (@(posedge clk) disable iff (!rst_n)
    !busy |-> !(mem_we || mem_re));

  p_done_at_end_r9: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(busy) |-> done);

  p_done_pulse_r9: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> !done);

  p_skip_with_done_r4: assert property (@(posedge clk) disable iff (!rst_n)
    skip_next |-> done);

  p_drop_flag_r11: assert property (@(posedge clk) disable iff (!rst_n)
    (op_valid && busy) |=> err);

  p_sp_hold_r10: assert property (@(posedge clk) disable iff (!rst_n)
    !done |-> $stable(sp_out));

  p_pc_hold_r10: assert property (@(posedge clk) disable iff (!rst_n)
    !done |-> $stable(pc_out));

endmodule

bind nib_stack_seq nss_chk #(.SP_W(SP_W), .PC_W(PC_W)) u_chk (
  .clk       (clk),
  .rst_n     (rst_n),
  .op_valid  (op_valid),
  .busy      (busy),
  .done      (done),
  .skip_next (skip_next),
  .err       (err),
  .mem_we    (mem_we),
  .mem_re    (mem_re),
  .sp_out    (sp_out),
  .pc_out    (pc_out)
);

// File: tb/nib_stack_seq_bench.sv
`timescale 1ns/1ps
module nib_stack_seq_bench;

  localparam logic [3:0] C_CALL = 4'd0, C_FCALL = 4'd1, C_RET = 4'd2, C_RETSK = 4'd3,
                         C_RETI = 4'd4, C_PUSHRP = 4'd5, C_POPRP = 4'd6,
                         C_PUSHBS = 4'd7, C_POPBS = 4'd8;

  logic        clk = 1'b0;
  logic        rst_n;
  logic        op_valid;
  logic        op_ready;
  logic [3:0]  op_code;
  logic [13:0] tgt_addr;
  logic [7:0]  rp_in;
  logic [7:0]  sp_in;
  logic [13:0] pc_in;
  logic        mbe_in;
  logic [3:0]  bank_in;
  logic [7:0]  psw_in;
  logic        mem_we, mem_re;
  logic [7:0]  mem_addr;
  logic [3:0]  mem_wdata, mem_rdata;
  logic        busy, done, skip_next, err;
  logic [7:0]  sp_out;
  logic [13:0] pc_out;
  logic        mbe_out;
  logic [3:0]  bank_out;
  logic [7:0]  psw_out, rp_out;

  always #2.5 clk = ~clk;

  nib_stack_seq u_nib_stack_seq (
    .clk(clk), .rst_n(rst_n), .op_valid(op_valid), .op_ready(op_ready),
    .op_code(op_code), .tgt_addr(tgt_addr), .rp_in(rp_in), .sp_in(sp_in),
    .pc_in(pc_in), .mbe_in(mbe_in), .bank_in(bank_in), .psw_in(psw_in),
    .mem_we(mem_we), .mem_re(mem_re), .mem_addr(mem_addr),
    .mem_wdata(mem_wdata), .mem_rdata(mem_rdata), .busy(busy), .done(done),
    .skip_next(skip_next), .err(err), .sp_out(sp_out), .pc_out(pc_out),
    .mbe_out(mbe_out), .bank_out(bank_out), .psw_out(psw_out), .rp_out(rp_out)
  );

  // synchronous nibble memory, read data one cycle after the strobe
  logic [3:0] mem [256];
  logic [3:0] rdq = 4'h0;
  always @(posedge clk) begin
    if (mem_we) mem[mem_addr] <= mem_wdata;
    if (mem_re) rdq <= mem[mem_addr];
  end
  assign mem_rdata = rdq;

  int n_chk  = 0;
  int n_fail = 0;
  int lat;
  logic busy1, skip_seen;

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s act=%0h exp=%0h", req, act, exp);
    end
  endtask

  // called at a negedge; returns at the negedge where done is high
  task automatic run_op(input logic [3:0] op, input logic [13:0] tgt, input logic [7:0] rp,
                        input logic [7:0] sp, input logic [13:0] pc, input logic mb,
                        input logic [3:0] bk, input logic [7:0] ps);
    op_code = op; tgt_addr = tgt; rp_in = rp; sp_in = sp; pc_in = pc;
    mbe_in = mb; bank_in = bk; psw_in = ps; op_valid = 1'b1;
    lat = 0; skip_seen = 1'b0; busy1 = 1'b0;
    for (int c = 1; c <= 40; c++) begin
      @(negedge clk);
      if (c == 1) begin
        op_valid = 1'b0;
        busy1 = busy;
      end
      if (done) begin
        lat = c;
        skip_seen = skip_next;
        break;
      end
    end
    if (lat == 0) begin
      n_chk++; n_fail++;
      $display("FAIL R9 no done act=0 exp=1");
    end
  endtask

  task automatic t_reset();
    chk("R9 busy after reset", busy, 0);
    chk("R9 ready after reset", op_ready, 1);
    chk("R9 done after reset", done, 0);
    chk("R10 sp after reset", sp_out, 0);
    chk("R12 strobes idle", {mem_we, mem_re}, 0);
  endtask

  task automatic t_call();
    run_op(C_CALL, 14'h1234, 8'h00, 8'h80, 14'h1ABC, 1'b1, 4'h0, 8'h00);
    chk("R9 call latency", lat, 5);
    chk("R9 busy in first access", busy1, 1);
    chk("R1 slot SP-4", mem[8'h7C], 4'hA);
    chk("R1 slot SP-1", mem[8'h7F], 4'hB);
    chk("R1 slot SP-2", mem[8'h7E], 4'hC);
    chk("R1 slot SP-3 packed", mem[8'h7D], 4'h9);
    chk("R1 pc", pc_out, 14'h1234);
    chk("R1 sp", sp_out, 8'h7C);
    chk("R10 mbe passes", mbe_out, 1);
    chk("R4 no skip on call", skip_seen, 0);
    repeat (3) @(negedge clk);
    chk("R10 sp holds", sp_out, 8'h7C);
  endtask

  task automatic t_fcall();
    run_op(C_FCALL, 14'h3FFF, 8'h00, 8'h40, 14'h3456, 1'b0, 4'h0, 8'h00);
    chk("R9 fast call latency", lat, 5);
    chk("R2 slot SP-3 packed", mem[8'h3D], 4'h3);
    chk("R2 slot SP-4", mem[8'h3C], 4'h4);
    chk("R2 slot SP-1", mem[8'h3F], 4'h5);
    chk("R2 slot SP-2", mem[8'h3E], 4'h6);
    chk("R2 pc", pc_out, 14'h07FF);
    chk("R2 sp", sp_out, 8'h3C);
  endtask

  task automatic t_ret();
    mem[8'h61] = 4'hE; mem[8'h60] = 4'h7; mem[8'h63] = 4'h8; mem[8'h62] = 4'h9;
    run_op(C_RET, 14'h0, 8'h00, 8'h60, 14'h0000, 1'b0, 4'h0, 8'h00);
    chk("R9 return latency", lat, 6);
    chk("R3 pc", pc_out, 14'h2789);
    chk("R3 mbe from bit3", mbe_out, 1);
    chk("R3 sp", sp_out, 8'h64);
    chk("R4 no skip on return", skip_seen, 0);
  endtask

  task automatic t_rets();
    mem[8'h21] = 4'h3; mem[8'h20] = 4'h1; mem[8'h23] = 4'h2; mem[8'h22] = 4'h3;
    run_op(C_RETSK, 14'h0, 8'h00, 8'h20, 14'h0000, 1'b1, 4'h0, 8'h00);
    chk("R9 skip return latency", lat, 6);
    chk("R4 skip with done", skip_seen, 1);
    chk("R4 pc", pc_out, 14'h3123);
    chk("R4 mbe cleared", mbe_out, 0);
    chk("R4 sp", sp_out, 8'h24);
    @(negedge clk);
    chk("R4 skip one cycle", skip_next, 0);
  endtask

  task automatic t_reti();
    mem[8'h11] = 4'h6; mem[8'h10] = 4'h4; mem[8'h13] = 4'h5; mem[8'h12] = 4'h6;
    mem[8'h14] = 4'hA; mem[8'h15] = 4'h5;
    run_op(C_RETI, 14'h0, 8'h00, 8'h10, 14'h0000, 1'b1, 4'h0, 8'h00);
    chk("R9 interrupt return latency", lat, 8);
    chk("R5 pc", pc_out, 14'h2456);
    chk("R5 mbe kept", mbe_out, 1);
    chk("R5 psw", psw_out, 8'hA5);
    chk("R5 sp", sp_out, 8'h16);
  endtask

  task automatic t_pair();
    run_op(C_PUSHRP, 14'h0, 8'hC3, 8'h90, 14'h0055, 1'b0, 4'h0, 8'h00);
    chk("R9 pair push latency", lat, 3);
    chk("R6 high nibble", mem[8'h8F], 4'hC);
    chk("R6 low nibble", mem[8'h8E], 4'h3);
    chk("R6 push sp", sp_out, 8'h8E);
    // back-to-back: pop offered in the done cycle of the push
    chk("R9 ready in done cycle", {done, op_ready}, 2'b11);
    run_op(C_POPRP, 14'h0, 8'h00, 8'h8E, 14'h0155, 1'b0, 4'h0, 8'h00);
    chk("R9 pair pop latency", lat, 4);
    chk("R6 pop pair", rp_out, 8'hC3);
    chk("R6 pop sp", sp_out, 8'h90);
    chk("R10 pc from input", pc_out, 14'h0155);
  endtask

  task automatic t_bank();
    mem[8'h4E] = 4'hF;
    run_op(C_PUSHBS, 14'h0, 8'h00, 8'h50, 14'h0, 1'b0, 4'h6, 8'h00);
    chk("R9 bank push latency", lat, 3);
    chk("R7 bank slot", mem[8'h4F], 4'h6);
    chk("R7 zero slot", mem[8'h4E], 4'h0);
    chk("R7 push sp", sp_out, 8'h4E);
    run_op(C_POPBS, 14'h0, 8'h00, 8'h4E, 14'h0, 1'b0, 4'h0, 8'h00);
    chk("R9 bank pop latency", lat, 3);
    chk("R7 pop bank", bank_out, 4'h6);
    chk("R7 pop sp", sp_out, 8'h50);
  endtask

  task automatic t_wrap();
    run_op(C_CALL, 14'h0200, 8'h00, 8'h02, 14'h0123, 1'b0, 4'h0, 8'h00);
    chk("R8 wrap SP-4", mem[8'hFE], 4'h1);
    chk("R8 wrap SP-3", mem[8'hFF], 4'h0);
    chk("R8 wrap SP-2", mem[8'h00], 4'h3);
    chk("R8 wrap SP-1", mem[8'h01], 4'h2);
    chk("R8 wrap sp", sp_out, 8'hFE);
    run_op(C_RET, 14'h0, 8'h00, 8'hFE, 14'h0, 1'b1, 4'h0, 8'h00);
    chk("R8 wrap return pc", pc_out, 14'h0123);
    chk("R8 wrap return sp", sp_out, 8'h02);
    chk("R8 wrap return mbe", mbe_out, 0);
  endtask

  task automatic t_drop();
    int c;
    op_code = C_CALL; tgt_addr = 14'h0100; sp_in = 8'h30; pc_in = 14'h0456;
    mbe_in = 1'b0; rp_in = 8'h00; op_valid = 1'b1;
    @(negedge clk);
    chk("R11 err on accept", err, 0);
    op_code = C_PUSHRP; rp_in = 8'hFF;     // offered while busy
    @(negedge clk);
    chk("R11 err after busy offer", err, 1);
    op_valid = 1'b0;
    c = 2;
    while (!done && c < 40) begin
      @(negedge clk);
      c++;
    end
    chk("R11 call latency kept", c, 5);
    chk("R11 frame untouched", mem[8'h2F], 4'h5);
    chk("R11 sp from call", sp_out, 8'h2C);
    chk("R11 pc from call", pc_out, 14'h0100);
    // undefined code while idle
    @(negedge clk);
    op_code = 4'hC; op_valid = 1'b1;
    @(negedge clk);
    op_valid = 1'b0;
    chk("R11 err on undefined", err, 1);
    chk("R11 not busy", busy, 0);
    @(negedge clk);
    chk("R11 err single", err, 0);
    chk("R11 sp unchanged", sp_out, 8'h2C);
  endtask

  initial begin
    rst_n = 1'b0; op_valid = 1'b0; op_code = 4'h0; tgt_addr = '0; rp_in = '0;
    sp_in = '0; pc_in = '0; mbe_in = 1'b0; bank_in = '0; psw_in = '0;
    for (int i = 0; i < 256; i++) mem[i] = 4'h0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    t_reset();
    t_call();
    t_fcall();
    t_ret();
    t_rets();
    t_reti();
    t_pair();
    t_bank();
    t_wrap();
    t_drop();
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end

  initial begin
    #(200000 * 5);
    n_chk++; n_fail++;
    $display("FAIL R9 watchdog act=1 exp=0");
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end

endmodule